// File: doc/BRIEF.md
# PWM Clock Source Selector

This block turns one bus clock into four single-cycle enable streams and gives each PWM channel the stream it asks for. Two plain sources, A and B, come from power-of-two prescalers that share one free-running phase counter. Two scaled sources, SA and SB, divide A and B further by an even factor held in an 8-bit scale register each. Every output is an enable pulse one bus cycle wide, synchronous to the bus clock. The PWM counters that consume these enables live elsewhere.

The channels are wired to a fixed clock pair. Channels whose index modulo 4 is 0 or 1 (0, 1, 4, 5 with six channels) choose between A and SA. Channels whose index modulo 4 is 2 or 3 (2 and 3) choose between B and SB. One select bit per channel picks the plain or the scaled member of its pair. A wait-stop control can freeze the whole tree while the system sits in a wait state.

Top module: `pwm_clock_select`

## Requirements
- R1: With `presc_a` = N (0..7), `tick_a` is high on exactly those running cycles in which the phase counter, which counts running cycles since reset starting at 0, has its low N bits all ones; so A pulses every 2^N running cycles, and N = 0 gives a pulse on every running cycle.
- R2: `tick_b` follows the same rule as R1 with `presc_b`, using the same shared phase counter.
- R3: With scale value M in the A scaler (M = 0 counts as 256), `tick_sa` is high on the A tick that completes 2×M A ticks since the last restart, and only on an A tick; its counter then starts over.
- R4: `tick_sb` follows the same rule as R3 for the B scaler, counting B ticks.
- R5: A cycle with `scale_a_we` (or `scale_b_we`) high loads the write data as the new M, restarts that scaler's count at zero and produces no scaled tick from that scaler in the same cycle; the first scaled tick after it is the 2×M-th plain tick after the write cycle.
- R6: For channel i, select bit 0 passes the plain source of its pair and bit 1 the scaled source; channels with i mod 4 in {0,1} use A/SA and channels with i mod 4 in {2,3} use B/SB.
- R7: While `wait_stop_en` and `wait_req` are both high, all four source ticks and all channel ticks are low and neither the phase counter nor the scaler counts advance; with `wait_stop_en` low, `wait_req` has no effect.
- R8: While `rst` is high all ticks are low; reset clears the phase counter, both scaler counts, and both scale registers to 0 (an effective scale of 256).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wait_req | input | 1 | System is in wait state |
| wait_stop_en | input | 1 | Freeze the tree while `wait_req` is high |
| presc_a | input | 3 | Prescaler exponent for source A |
| presc_b | input | 3 | Prescaler exponent for source B |
| scale_a_we | input | 1 | Write strobe for the A scale register |
| scale_a_wdata | input | 8 | New A scale value (0 means 256) |
| scale_b_we | input | 1 | Write strobe for the B scale register |
| scale_b_wdata | input | 8 | New B scale value (0 means 256) |
| chan_sel | input | 6 | Per-channel pick: 0 plain, 1 scaled |
| tick_a | output | 1 | Enable pulse of source A |
| tick_b | output | 1 | Enable pulse of source B |
| tick_sa | output | 1 | Enable pulse of source SA |
| tick_sb | output | 1 | Enable pulse of source SB |
| chan_tick | output | 6 | Enable pulse delivered to each channel |

## Verification
Two events collide in the same cycle here: a scale register write landing on a plain tick that would otherwise advance or fire the scaler, and a wait freeze landing on a cycle where a tick is due. The bench provokes the first by writing scale registers with the prescaler at 0, where every running cycle is an A tick, and by random writes at other rates; it provokes the second with random wait bursts across every prescaler setting. A bench model counting running cycles and plain ticks since each restart judges every cycle, so a suppressed, late or extra scaled tick and a tick that leaks through a freeze both show as mismatches.

// File: rtl/pwmclk_pkg.sv
package pwmclk_pkg;
    localparam int PRE_W  = 3;
    localparam int SCL_W  = 8;
    localparam int NUM_CH = 6;

    // Pair of enable strobes a channel can choose from.
    typedef struct packed {
        logic plain;
        logic scaled;
    } src_pair_t;

    // Channel-to-pair wiring: index mod 4 of 2 or 3 uses the B pair.
    function automatic bit uses_pair_b(int ch);
        return (ch % 4) >= 2;
    endfunction
endpackage

// File: rtl/pwmclk_prescale.sv
module pwmclk_prescale #(
    parameter int PRE_W = pwmclk_pkg::PRE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic [PRE_W-1:0] exp_a,
    input  logic [PRE_W-1:0] exp_b,
    output logic             tick_a,
    output logic             tick_b
);
    localparam int CNT_W = (1 << PRE_W) - 1;

    logic [CNT_W-1:0] phase;
    logic [CNT_W-1:0] mask_a, mask_b;
    logic             run;

    assign run    = ~rst & ~hold;
    assign mask_a = ~({CNT_W{1'b1}} << exp_a);
    assign mask_b = ~({CNT_W{1'b1}} << exp_b);
    assign tick_a = run & ((phase & mask_a) == mask_a);
    assign tick_b = run & ((phase & mask_b) == mask_b);

    always_ff @(posedge clk) begin
        if (rst)      phase <= '0;
        else if (run) phase <= phase + 1'b1;
    end

    AST_HOLD_QUIET:  assert property (@(posedge clk) disable iff (rst)
        hold |-> (!tick_a && !tick_b));                        // R7
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        hold |=> (phase == $past(phase)));                     // R7
    AST_EXP0_EVERY:  assert property (@(posedge clk) disable iff (rst)
        (!hold && exp_a == '0) |-> tick_a);                    // R1
endmodule

// File: rtl/pwmclk_scaler.sv
module pwmclk_scaler #(
    parameter int SCL_W = pwmclk_pkg::SCL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_in,
    input  logic             wr,
    input  logic [SCL_W-1:0] wdata,
    output logic             tick_out
);
    localparam int CNT_W = SCL_W + 1;
    localparam int LIM_W = SCL_W + 2;

    logic [SCL_W-1:0] scale_q;
    logic [CNT_W-1:0] cnt;
    logic [LIM_W-1:0] limit;
    logic             at_end;

    assign limit    = (scale_q == '0) ? LIM_W'(1) << (SCL_W + 1)
                                      : {1'b0, scale_q, 1'b0};
    assign at_end   = ({1'b0, cnt} == limit - 1'b1);
    assign tick_out = tick_in & ~wr & at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            scale_q <= '0;
            cnt     <= '0;
        end else if (wr) begin
            scale_q <= wdata;
            cnt     <= '0;
        end else if (tick_in) begin
            cnt <= at_end ? '0 : cnt + 1'b1;
        end
    end

    AST_SCALED_SUBSET: assert property (@(posedge clk) disable iff (rst)
        tick_out |-> tick_in);                                 // R3
    AST_WR_RESTART:    assert property (@(posedge clk) disable iff (rst)
        wr |=> (cnt == '0));                                   // R5
    AST_NO_OVERFLOW:   assert property (@(posedge clk) disable iff (rst)
        ({1'b0, cnt} < limit));                                // R3
    AST_IDLE_STILL:    assert property (@(posedge clk) disable iff (rst)
        (!tick_in && !wr) |=> $stable(cnt));                   // R7
endmodule

// File: rtl/pwm_clock_select.sv
module pwm_clock_select
    import pwmclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wait_req,
    input  logic              wait_stop_en,
    input  logic [PRE_W-1:0]  presc_a,
    input  logic [PRE_W-1:0]  presc_b,
    input  logic              scale_a_we,
    input  logic [SCL_W-1:0]  scale_a_wdata,
    input  logic              scale_b_we,
    input  logic [SCL_W-1:0]  scale_b_wdata,
    input  logic [NUM_CH-1:0] chan_sel,
    output logic              tick_a,
    output logic              tick_b,
    output logic              tick_sa,
    output logic              tick_sb,
    output logic [NUM_CH-1:0] chan_tick
);
    logic      frozen;
    src_pair_t pair_a, pair_b;

    assign frozen = wait_stop_en & wait_req;

    pwmclk_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst(rst), .hold(frozen),
        .exp_a(presc_a), .exp_b(presc_b),
        .tick_a(tick_a), .tick_b(tick_b)
    );

    pwmclk_scaler #(.SCL_W(SCL_W)) u_scl_a (
        .clk(clk), .rst(rst), .tick_in(tick_a),
        .wr(scale_a_we), .wdata(scale_a_wdata), .tick_out(tick_sa)
    );

    pwmclk_scaler #(.SCL_W(SCL_W)) u_scl_b (
        .clk(clk), .rst(rst), .tick_in(tick_b),
        .wr(scale_b_we), .wdata(scale_b_wdata), .tick_out(tick_sb)
    );

    assign pair_a = '{plain: tick_a, scaled: tick_sa};
    assign pair_b = '{plain: tick_b, scaled: tick_sb};

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        src_pair_t src;
        if (uses_pair_b(i)) begin : g_b
            assign src = pair_b;
        end else begin : g_a
            assign src = pair_a;
        end
        assign chan_tick[i] = chan_sel[i] ? src.scaled : src.plain;

        AST_CHAN_FROM_PAIR: assert property (@(posedge clk) disable iff (rst)
            chan_tick[i] |-> (uses_pair_b(i) ? (tick_b || tick_sb)
                                             : (tick_a || tick_sa)));   // R6
    end

    AST_FROZEN_SILENT: assert property (@(posedge clk) disable iff (rst)
        frozen |-> (chan_tick == '0 && !tick_sa && !tick_sb));          // R7
endmodule

// File: tb/sim_pwm_clock_select.sv
module sim_pwm_clock_select;
    logic       clk = 1'b0;
    logic       rst;
    logic       wait_req, wait_stop_en;
    logic [2:0] presc_a, presc_b;
    logic       scale_a_we, scale_b_we;
    logic [7:0] scale_a_wdata, scale_b_wdata;
    logic [5:0] chan_sel;
    logic       tick_a, tick_b, tick_sa, tick_sb;
    logic [5:0] chan_tick;

    int n_checks = 0;
    int n_fail   = 0;
    // model state
    int ph = 0, ka = 0, kb = 0, ma = 0, mb = 0;

    always #4 clk = ~clk;

    pwm_clock_select u0 (
        .clk(clk), .rst(rst), .wait_req(wait_req), .wait_stop_en(wait_stop_en),
        .presc_a(presc_a), .presc_b(presc_b),
        .scale_a_we(scale_a_we), .scale_a_wdata(scale_a_wdata),
        .scale_b_we(scale_b_we), .scale_b_wdata(scale_b_wdata),
        .chan_sel(chan_sel), .tick_a(tick_a), .tick_b(tick_b),
        .tick_sa(tick_sa), .tick_sb(tick_sb), .chan_tick(chan_tick)
    );

    task automatic check(string req, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: got %0h expected %0h", req, $time, got, exp);
        end
    endtask

    function automatic bit plain_due(int phase, int n);
        return (phase % (1 << n)) == (1 << n) - 1;
    endfunction

    function automatic int lim_of(int m);
        return (m == 0) ? 512 : 2 * m;
    endfunction

    // One cycle: inputs already driven after negedge; compare, advance model.
    task automatic step();
        bit run, ea, eb, esa, esb;
        logic [5:0] ech;
        #1;
        run = !(wait_stop_en && wait_req);
        ea  = run && plain_due(ph, int'(presc_a));            // R1
        eb  = run && plain_due(ph, int'(presc_b));            // R2
        esa = ea && !scale_a_we && (ka == lim_of(ma) - 1);    // R3 R5
        esb = eb && !scale_b_we && (kb == lim_of(mb) - 1);    // R4 R5
        for (int i = 0; i < 6; i++) begin
            if ((i % 4) >= 2) ech[i] = chan_sel[i] ? esb : eb;
            else              ech[i] = chan_sel[i] ? esa : ea;
        end
        check(run ? "R1" : "R7", int'(tick_a), int'(ea));
        check(run ? "R2" : "R7", int'(tick_b), int'(eb));
        check(scale_a_we ? "R5" : "R3", int'(tick_sa), int'(esa));
        check(scale_b_we ? "R5" : "R4", int'(tick_sb), int'(esb));
        check("R6", int'(chan_tick), int'(ech));
        if (run) ph++;
        if (scale_a_we) begin ma = int'(scale_a_wdata); ka = 0; end
        else if (ea) ka = (ka == lim_of(ma) - 1) ? 0 : ka + 1;
        if (scale_b_we) begin mb = int'(scale_b_wdata); kb = 0; end
        else if (eb) kb = (kb == lim_of(mb) - 1) ? 0 : kb + 1;
        @(negedge clk);
        scale_a_we = 1'b0;
        scale_b_we = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; wait_req = 1'b0; wait_stop_en = 1'b0;
        presc_a = 3'd0; presc_b = 3'd0; chan_sel = '0;
        scale_a_we = 1'b0; scale_b_we = 1'b0;
        scale_a_wdata = '0; scale_b_wdata = '0;
        @(negedge clk); @(negedge clk);
        #1;
        // R8: all quiet during reset even with prescaler 0
        check("R8", int'({tick_a, tick_b, tick_sa, tick_sb}), 0);
        check("R8", int'(chan_tick), 0);
        @(negedge clk);
        rst = 1'b0;

        // Directed: reset scale 0 behaves as 256 -> SA every 512 A ticks (R8, R3)
        presc_a = 3'd0; presc_b = 3'd1; chan_sel = 6'b001101;
        repeat (1100) step();

        // Directed: write collides with A tick every cycle (R5)
        scale_a_wdata = 8'd3; scale_a_we = 1'b1;
        scale_b_wdata = 8'd2; scale_b_we = 1'b1;
        repeat (40) step();
        scale_a_wdata = 8'd1; scale_a_we = 1'b1;
        repeat (7) step();
        scale_a_wdata = 8'd1; scale_a_we = 1'b1;
        repeat (10) step();

        // Directed: wait-stop clear -> wait_req ignored (R7)
        wait_req = 1'b1; wait_stop_en = 1'b0;
        repeat (30) step();
        // Directed: freeze, with a scale write during it (R7, R5)
        wait_stop_en = 1'b1;
        repeat (10) step();
        scale_b_wdata = 8'd4; scale_b_we = 1'b1;
        repeat (10) step();
        wait_req = 1'b0;
        repeat (60) step();

        // Directed: slowest prescaler (R1, R2)
        presc_a = 3'd7; presc_b = 3'd7; chan_sel = 6'b110011;
        scale_a_wdata = 8'd1; scale_a_we = 1'b1;
        repeat (600) step();

        // Random segments
        for (int s = 0; s < 40; s++) begin
            presc_a      = 3'($urandom_range(0, 3));
            presc_b      = 3'($urandom_range(0, 3));
            chan_sel     = 6'($urandom);
            wait_stop_en = 1'($urandom);
            for (int c = 0; c < 250; c++) begin
                wait_req = ($urandom_range(0, 9) < 2);
                if ($urandom_range(0, 59) == 0) begin
                    scale_a_wdata = 8'($urandom_range(0, 6));
                    scale_a_we = 1'b1;
                end
                if ($urandom_range(0, 59) == 0) begin
                    scale_b_wdata = 8'($urandom_range(1, 6));
                    scale_b_we = 1'b1;
                end
                step();
            end
        end

        // Mid-run reset (R8)
        rst = 1'b1; wait_req = 1'b0;
        @(negedge clk);
        #1;
        check("R8", int'(chan_tick), 0);
        @(negedge clk);
        rst = 1'b0;
        ph = 0; ka = 0; kb = 0; ma = 0; mb = 0;
        presc_a = 3'd0; presc_b = 3'd0; chan_sel = 6'b111111;
        repeat (520) step();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule